// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block decides, for each received Ethernet frame, whether the frame is wanted by the station. It watches the destination address arriving byte by byte, starting on a start-of-frame strobe. While the bytes stream in it folds them into a reflected CRC-32, and at the same time it keeps a copy of the six address bytes. One cycle after the sixth byte it raises a single-cycle valid pulse together with an accept/reject flag.

Group (multicast) addresses are filtered through a 64-bit hash table. The top six bits of the CRC select one table bit, and a set bit lets the frame through. Individual (unicast) addresses must equal a programmed station address. The all-ones broadcast address always passes. A promiscuous input overrides all filtering. The table and the station address are loaded through a simple register write port.

The block does no frame buffering and no frame check sequence verification. It sits beside the receive datapath and only produces the decision.

Top module: `mcast_addr_filter`

## Requirements
- R1: After reset both hash words and the station address are zero and `dec_valid` is low, so a group frame sent before any write is rejected.
- R2: The hash index is bits 31:26 of a CRC register seeded with 0xFFFFFFFF. All six address bytes are folded into it in arrival order, each byte least-significant bit first. Each bit step shifts the register right by one and XORs in 0xEDB88320 when bit 0 of (register XOR data) is 1. No final inversion is applied.
- R3: Write select 0 loads the low hash word and select 1 loads the high hash word. An index of 32 to 63 tests bit (index−32) of the high word, and an index of 0 to 31 tests bit (index) of the low word.
- R4: A group frame (bit 0 of the first address byte is 1) that is not broadcast is accepted exactly when its hash bit is set. With both words all ones, every group frame is accepted.
- R5: Write select 2 holds address bytes 0..3, with byte 0 in bits 31:24. Write select 3 holds bytes 4 and 5 in bits 31:24 and 23:16, and its bits 15:0 have no effect. A unicast frame is accepted exactly when all six bytes equal this address, and the hash table has no effect on unicast frames.
- R6: The destination FF:FF:FF:FF:FF:FF is accepted even when both hash words are zero.
- R7: While `cfg_promisc` is 1, every decision is accept.
- R8: `dec_valid` is high for exactly the one cycle after the cycle in which the sixth byte is taken. Bytes that arrive after the sixth and before the next start strobe change neither the outputs nor the next decision.
- R9: A start strobe in the middle of an address restarts collection, so the six bytes beginning at that strobe form the address. Bytes without a strobe while no frame is being collected are ignored. Idle cycles between address bytes are allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_vld | input | 1 | Address byte present on `byte_in` this cycle |
| sof | input | 1 | Qualified by `byte_vld`: this byte is the first destination byte |
| byte_in | input | 8 | Received byte |
| cfg_promisc | input | 1 | Accept every frame |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 hash low, 1 hash high, 2 station bytes 0..3, 3 station bytes 4..5 |
| wr_data | input | 32 | Register write data |
| dec_valid | output | 1 | One-cycle decision pulse |
| dec_accept | output | 1 | Decision, meaningful while `dec_valid` is high |

## Verification
The bench builds the block with its default parameters: six address bytes, a six-bit hash index and 32-bit registers. This gives two hash words and a two-bit write select, so every register can be reached through the write port.

The bench searches a range of group addresses at run time with its own CRC routine. It keeps one address that lands in the high word and one that lands in the low word, which lets single-bit table settings expose index and word-selection faults. Gapped byte streams, trailing bytes and restarted frames exercise the collection sequencing on every cycle.

// File: rtl/mhf_pkg.sv
package mhf_pkg;

  localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;

  typedef logic [7:0] octet_t;

  // One byte folded into a reflected CRC-32, bit 0 first.
  function automatic logic [31:0] crc_fold_byte(input logic [31:0] c_in,
                                                input octet_t      d);
    logic [31:0] c;
    c = c_in;
    for (int b = 0; b < 8; b++) begin
      if (c[0] ^ d[b]) c = (c >> 1) ^ CRC_POLY;
      else             c = c >> 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/mhf_frame_seq.sv
module mhf_frame_seq #(
  parameter int ADDR_BYTES = 6,
  localparam int CNT_W = $clog2(ADDR_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_vld,
  input  logic             sof,
  output logic             take_first,
  output logic             take_byte,
  output logic [CNT_W-1:0] byte_pos,
  output logic             frame_done
);

  logic             active_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic             take_next;

  assign take_first = byte_vld & sof;
  assign take_next  = byte_vld & ~sof & active_q;
  assign take_byte  = take_first | take_next;
  assign byte_pos   = take_first ? '0 : cnt_q;
  assign frame_done = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (take_first) begin
        active_q <= 1'b1;
        cnt_q    <= CNT_W'(1);
      end else if (take_next) begin
        cnt_q <= cnt_q + CNT_W'(1);
        if (cnt_q == CNT_W'(ADDR_BYTES - 1)) begin
          active_q <= 1'b0;
          done_q   <= 1'b1;
        end
      end
    end
  end

  // R8: the byte counter never runs past the address length
  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(ADDR_BYTES));

  // R8: completion is preceded by consuming the last address byte
  p_done_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(take_next));

endmodule

// File: rtl/mhf_crc_acc.sv
module mhf_crc_acc
  import mhf_pkg::*;
#(
  parameter int HASH_BITS = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 take_first,
  input  logic                 take_byte,
  input  octet_t               byte_in,
  output logic [HASH_BITS-1:0] hash_idx
);

  logic [31:0] crc_q;
  logic [31:0] crc_base;

  assign crc_base = take_first ? CRC_SEED : crc_q;
  assign hash_idx = crc_q[31 -: HASH_BITS];

  always_ff @(posedge clk) begin
    if (!rst_n)         crc_q <= CRC_SEED;
    else if (take_byte) crc_q <= crc_fold_byte(crc_base, byte_in);
  end

  // R2: the register only moves when a byte is taken
  p_crc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !take_byte |=> $stable(crc_q));

endmodule

// File: rtl/mhf_addr_cap.sv
module mhf_addr_cap
  import mhf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  localparam int CNT_W  = $clog2(ADDR_BYTES + 1),
  localparam int ADDR_W = 8 * ADDR_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_byte,
  input  logic [CNT_W-1:0]  byte_pos,
  input  octet_t            byte_in,
  output logic [ADDR_W-1:0] addr,
  output logic              is_group,
  output logic              is_bcast
);

  // Byte 0 (first on the wire) sits in the most significant position.
  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_byte
    octet_t slot_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        slot_q <= '0;
      else if (take_byte && byte_pos == CNT_W'(g))
        slot_q <= byte_in;
    end
    assign addr[ADDR_W-1-8*g -: 8] = slot_q;
  end

  assign is_group = addr[ADDR_W-8];
  assign is_bcast = &addr;

endmodule

// File: rtl/mhf_filter_regs.sv
module mhf_filter_regs #(
  parameter int HASH_BITS  = 6,
  parameter int REG_W      = 32,
  parameter int ADDR_BYTES = 6,
  localparam int TABLE_BITS  = 1 << HASH_BITS,
  localparam int NUM_HREG    = TABLE_BITS / REG_W,
  localparam int SEL_W       = $clog2(NUM_HREG + 2),
  localparam int ADDR_W      = 8 * ADDR_BYTES,
  localparam int STA_LO_BITS = ADDR_W - REG_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [SEL_W-1:0]      wr_sel,
  input  logic [REG_W-1:0]      wr_data,
  output logic [TABLE_BITS-1:0] table_bits,
  output logic [ADDR_W-1:0]     station
);

  for (genvar h = 0; h < NUM_HREG; h++) begin : g_hword
    logic [REG_W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        word_q <= '0;
      else if (wr_en && wr_sel == SEL_W'(h))
        word_q <= wr_data;
    end
    assign table_bits[h*REG_W +: REG_W] = word_q;
  end

  logic [REG_W-1:0]       sta_hi_q;
  logic [STA_LO_BITS-1:0] sta_lo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sta_hi_q <= '0;
      sta_lo_q <= '0;
    end else if (wr_en) begin
      if (wr_sel == SEL_W'(NUM_HREG))     sta_hi_q <= wr_data;
      if (wr_sel == SEL_W'(NUM_HREG + 1)) sta_lo_q <= wr_data[REG_W-1 -: STA_LO_BITS];
    end
  end

  assign station = {sta_hi_q, sta_lo_q};

  // R1: without a write the filter state does not move
  p_regs_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(table_bits) && $stable(station)));

endmodule

// File: rtl/mcast_addr_filter.sv
module mcast_addr_filter
  import mhf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS  = 6,
  parameter int REG_W      = 32,
  localparam int TABLE_BITS = 1 << HASH_BITS,
  localparam int NUM_HREG   = TABLE_BITS / REG_W,
  localparam int SEL_W      = $clog2(NUM_HREG + 2),
  localparam int CNT_W      = $clog2(ADDR_BYTES + 1),
  localparam int ADDR_W     = 8 * ADDR_BYTES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_vld,
  input  logic             sof,
  input  logic [7:0]       byte_in,
  input  logic             cfg_promisc,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [REG_W-1:0] wr_data,
  output logic             dec_valid,
  output logic             dec_accept
);

  logic                  take_first;
  logic                  take_byte;
  logic [CNT_W-1:0]      byte_pos;
  logic                  frame_done;
  logic [HASH_BITS-1:0]  hash_idx;
  logic [ADDR_W-1:0]     rx_addr;
  logic                  is_group;
  logic                  is_bcast;
  logic [TABLE_BITS-1:0] table_bits;
  logic [ADDR_W-1:0]     station;
  logic                  hash_hit;
  logic                  station_hit;

  mhf_frame_seq #(.ADDR_BYTES(ADDR_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .sof(sof),
    .take_first(take_first), .take_byte(take_byte),
    .byte_pos(byte_pos), .frame_done(frame_done)
  );

  mhf_crc_acc #(.HASH_BITS(HASH_BITS)) u_crc (
    .clk(clk), .rst_n(rst_n), .take_first(take_first),
    .take_byte(take_byte), .byte_in(byte_in), .hash_idx(hash_idx)
  );

  mhf_addr_cap #(.ADDR_BYTES(ADDR_BYTES)) u_cap (
    .clk(clk), .rst_n(rst_n), .take_byte(take_byte), .byte_pos(byte_pos),
    .byte_in(byte_in), .addr(rx_addr), .is_group(is_group), .is_bcast(is_bcast)
  );

  mhf_filter_regs #(.HASH_BITS(HASH_BITS), .REG_W(REG_W), .ADDR_BYTES(ADDR_BYTES)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .table_bits(table_bits), .station(station)
  );

  // Word h covers indices h*REG_W .. h*REG_W+REG_W-1, so the upper half of
  // the index range lands in the high word.
  assign hash_hit    = table_bits[hash_idx];
  assign station_hit = (rx_addr == station);

  assign dec_valid  = frame_done;
  assign dec_accept = frame_done &
                      (cfg_promisc | (is_group ? (is_bcast | hash_hit) : station_hit));

  // R8: the decision is a single-cycle pulse
  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid);

  // R7: promiscuous mode never rejects
  p_promisc_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && cfg_promisc) |-> dec_accept);

  // R6: broadcast passes regardless of table contents
  p_bcast_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && is_bcast) |-> dec_accept);

  // R5: a unicast mismatch is rejected outside promiscuous mode
  p_unicast_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !cfg_promisc && !is_group && rx_addr != station) |-> !dec_accept);

  // R4: an empty table rejects non-broadcast group frames
  p_empty_table_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !cfg_promisc && is_group && !is_bcast && table_bits == '0) |-> !dec_accept);

endmodule

// File: tb/mcast_addr_filter_tb_top.sv
module mcast_addr_filter_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        byte_vld;
  logic        sof;
  logic [7:0]  byte_in;
  logic        cfg_promisc;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [31:0] wr_data;
  logic        dec_valid;
  logic        dec_accept;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcast_addr_filter dut_i (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .sof(sof), .byte_in(byte_in),
    .cfg_promisc(cfg_promisc), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .dec_valid(dec_valid), .dec_accept(dec_accept)
  );

  // ---------------- reference model state ----------------
  logic [31:0] m_hash_lo, m_hash_hi, m_sta_a, m_sta_b;
  logic [7:0]  m_q[$];
  bit          m_collect;
  bit          m_done;
  int          vectors = 0;
  int          fails   = 0;
  bit          finished = 0;
  string       phase = "init";

  function automatic int ref_index(input logic [47:0] a);
    longint unsigned c = 64'hFFFF_FFFF;
    for (int i = 0; i < 6; i++) begin
      int d = int'(a[47-8*i -: 8]);
      for (int k = 0; k < 8; k++) begin
        if (((c ^ longint'(d)) & 1) != 0) c = (c >> 1) ^ 64'hEDB8_8320;
        else                               c = c >> 1;
        d = d >> 1;
      end
    end
    return int'(c / 64'd67108864);  // top six bits of 32
  endfunction

  function automatic logic [47:0] q_addr();
    logic [47:0] a = '0;
    for (int i = 0; i < 6; i++) a = {a[39:0], m_q[i]};
    return a;
  endfunction

  function automatic bit ref_accept(output string tag);
    logic [47:0] a = q_addr();
    int idx;
    if (cfg_promisc)          begin tag = "R7"; return 1'b1; end
    if (a == 48'hFFFF_FFFF_FFFF) begin tag = "R6"; return 1'b1; end
    if (a[40]) begin
      idx = ref_index(a);
      tag = "R4 (hash, R2 index, R3 word)";
      if (idx >= 32) return m_hash_hi[idx-32];
      return m_hash_lo[idx];
    end
    tag = "R5";
    return a == {m_sta_a, m_sta_b[31:16]};
  endfunction

  task automatic compare();
    bit    exp_v;
    bit    exp_a;
    string tag;
    exp_v = m_done;
    vectors++;
    if (dec_valid !== exp_v) begin
      fails++;
      $display("FAIL R8 [%s] dec_valid=%b expected=%b at %0t", phase, dec_valid, exp_v, $time);
    end else if (exp_v) begin
      exp_a = ref_accept(tag);
      if (dec_accept !== exp_a) begin
        fails++;
        $display("FAIL %s [%s] dec_accept=%b expected=%b at %0t", tag, phase, dec_accept, exp_a, $time);
      end
    end
  endtask

  task automatic model_edge();
    bit nd = 0;
    if (!rst_n) begin
      m_hash_lo = '0; m_hash_hi = '0; m_sta_a = '0; m_sta_b = '0;
      m_collect = 0; m_done = 0; m_q.delete();
      return;
    end
    if (byte_vld && sof) begin
      m_q.delete(); m_q.push_back(byte_in); m_collect = 1;
    end else if (byte_vld && m_collect) begin
      m_q.push_back(byte_in);
      if (m_q.size() == 6) begin m_collect = 0; nd = 1; end
    end
    if (wr_en) begin
      case (wr_sel)
        2'd0: m_hash_lo = wr_data;
        2'd1: m_hash_hi = wr_data;
        2'd2: m_sta_a   = wr_data;
        default: m_sta_b = wr_data;
      endcase
    end
    m_done = nd;
  endtask

  // One clock: check outputs, let the edge pass, update the model.
  task automatic cyc();
    #1 compare();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [31:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d;
    cyc();
    wr_en = 0;
  endtask

  task automatic send(input logic [47:0] a, input int gap, input int tail);
    for (int i = 0; i < 6; i++) begin
      byte_vld = 1; sof = (i == 0); byte_in = a[47-8*i -: 8];
      cyc();
      byte_vld = 0; sof = 0;
      for (int g = 0; g < gap; g++) cyc();
    end
    for (int t = 0; t < tail; t++) begin  // stray bytes after the address
      byte_vld = 1; byte_in = 8'hA5 ^ 8'(t);
      cyc();
    end
    byte_vld = 0;
    cyc(); cyc();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired in phase %s", phase);
    finish_run();
  end

  initial begin
    logic [47:0] a_hi, a_lo, cand;
    int ih, il;
    bit got_hi, got_lo;
    rst_n = 0; byte_vld = 0; sof = 0; byte_in = '0; cfg_promisc = 0;
    wr_en = 0; wr_sel = '0; wr_data = '0;
    model_edge();
    @(negedge clk);
    phase = "R1 reset";
    repeat (3) cyc();
    rst_n = 1;
    cyc();

    // R1: empty table after reset rejects a group frame
    phase = "R1 group before writes";
    send(48'h0100_5E00_0001, 0, 0);

    // R2/R3: find one address per hash word with the bench's own CRC
    got_hi = 0; got_lo = 0; a_hi = '0; a_lo = '0;
    for (int k = 0; k < 256 && !(got_hi && got_lo); k++) begin
      cand = {40'h01_00_5E_00_01, 8'(k)};
      if (ref_index(cand) >= 32 && !got_hi) begin a_hi = cand; got_hi = 1; end
      if (ref_index(cand) <  32 && !got_lo) begin a_lo = cand; got_lo = 1; end
    end
    ih = ref_index(a_hi); il = ref_index(a_lo);
    phase = "R3 high word single bit";
    wr_reg(2'd1, 32'(1) << (ih - 32));
    send(a_hi, 0, 0);
    send(a_lo, 0, 0);
    phase = "R3 low word single bit";
    wr_reg(2'd0, 32'(1) << il);
    send(a_lo, 1, 0);
    wr_reg(2'd1, 32'h0);
    send(a_hi, 0, 0);

    // R4: all ones accepts every group address; one cleared bit rejects
    phase = "R4 all ones";
    wr_reg(2'd0, 32'hFFFF_FFFF);
    wr_reg(2'd1, 32'hFFFF_FFFF);
    send(48'h3333_0000_0001, 0, 0);
    send(48'h0180_C200_000E, 0, 0);
    send(a_lo, 0, 0);
    phase = "R4 one bit cleared";
    wr_reg(2'd1, ~(32'(1) << (ih - 32)));
    send(a_hi, 0, 0);

    // R5: station match, partial mismatch, table has no effect on unicast
    phase = "R5 station";
    wr_reg(2'd2, 32'h0012_3456);
    wr_reg(2'd3, 32'h789A_1234);
    send(48'h0012_3456_789A, 0, 0);
    send(48'h0012_3456_789B, 0, 0);
    send(48'h0212_3456_789A, 2, 0);

    // R6: broadcast with empty table
    phase = "R6 broadcast";
    wr_reg(2'd0, 32'h0);
    wr_reg(2'd1, 32'h0);
    send(48'hFFFF_FFFF_FFFF, 0, 0);
    send(a_hi, 0, 0);

    // R7: promiscuous accepts a mismatching unicast and an unhashed group
    phase = "R7 promiscuous";
    cfg_promisc = 1;
    send(48'h00AA_BBCC_DDEE, 0, 0);
    send(a_lo, 0, 0);
    cfg_promisc = 0;

    // R8: trailing bytes after the sixth do not start a new decision
    phase = "R8 trailing bytes";
    send(48'h0012_3456_789A, 0, 3);
    send(48'h0012_3456_789A, 3, 2);

    // R9: restart mid-address, stray bytes while idle
    phase = "R9 restart";
    for (int i = 0; i < 3; i++) begin
      byte_vld = 1; sof = (i == 0); byte_in = 8'h11 * 8'(i + 1);
      cyc();
    end
    sof = 0; byte_vld = 0;
    send(48'h0012_3456_789A, 0, 0);
    phase = "R9 idle bytes";
    for (int i = 0; i < 8; i++) begin
      byte_vld = 1; sof = 0; byte_in = 8'(i);
      cyc();
    end
    byte_vld = 0;
    repeat (3) cyc();
    finish_run();
  end

endmodule